// File: doc/BRIEF.md
# Two-Domain Byte-Bus GPIO Controller

This block drives and samples fourteen general-purpose pins split into two banks that live in different power domains. Ten "core" pins (global numbers 0 to 9) belong to a domain that is switched off in deep sleep, so their registers are cleared by that domain's power-good. Four "retained" pins (global numbers 10 to 13, retained pin k being global pin 10+k) keep their configuration through suspend-to-RAM on a separate reset. While the system sleeps, a level change on a retained input raises a sticky wake request.

Software reaches the block over a byte-wide register bus with an address, write data, read data and separate read and write strobes. Each bank has three register groups: enable, direction and level. A pin is driven only when it is enabled and configured as an output; otherwise its output enable is low and the pad floats. Pin inputs go through a two-flop synchronizer before software reads them. Core pin 7 is set aside for a sleep-override function owned elsewhere, so this controller never enables or drives it.

Top module: `twin_domain_gpio`

## Requirements
- R1: After both resets, core enable reads 0x7F at offset 0x00 and 0x00 at 0x01, core direction reads 0xFF at 0x04 and 0x03 at 0x05, retained enable reads 0x07 at 0x20, retained direction reads 0x0F at 0x24, the wake register at 0x2C reads 0x00, and no pin is driven.
- R2: Core pin n is bit n%8 of the byte at group offset + n/8 (groups enable 0x00, direction 0x04, level 0x08); retained pin k is bit k of the byte at 0x20 (enable), 0x24 (direction) and 0x28 (level). Enable and direction bytes read back what was written.
- R3: A pin's output enable is 1 exactly when its enable bit is 1 and its direction bit is 0 (1 means input); the driven value is the bit last written to its level register.
- R4: Reading a level byte returns the pad level of each implemented pin after a two-flop synchronizer, whether the pin is an input or is being driven.
- R5: Bits beyond the implemented pins (bits 7:2 at 0x01/0x05/0x09, bits 7:4 in the retained bytes) and every unmapped offset read as 0; writes to them change nothing.
- R6: Core pin 7 is reserved: its enable bit always reads 0 and its output enable stays 0, whatever is written.
- R7: Deasserting the core power-good returns all core registers to their reset values and leaves the retained-bank registers unchanged.
- R8: The suspend-domain reset returns the retained-bank registers and the wake flag to their reset values.
- R9: While the sleep input is high, a level change on a retained pin that is enabled and configured as an input sets the wake flag (bit 0 at 0x2C) and the wake request output; changes while awake, on disabled pins or on output pins do not.
- R10: Writing 1 to bit 0 of 0x2C clears the wake flag, writing 0 leaves it set, and a wake event in the same cycle as a clearing write leaves the flag set.
- R11: Read data appears on the cycle after a read strobe is sampled and is 0 on every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and sampling clock |
| corePwrGoodN | input | 1 | Core-domain power-good, low resets the core bank |
| susRstN | input | 1 | Suspend-domain reset, active low |
| busAddr | input | 6 | Byte register offset |
| busWrData | input | 8 | Write data byte |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busRd | input | 1 | Read strobe, one cycle per byte |
| busRdData | output | 8 | Read data, valid the cycle after the read strobe |
| sleepIn | input | 1 | High while the system is in suspend |
| padIn | input | 14 | Pad levels, core pins in bits 9:0, retained in 13:10 |
| padOut | output | 14 | Value driven on each pad |
| padOe | output | 14 | Output enable per pad, low means tri-state |
| wakeReq | output | 1 | Sticky wake request from the retained bank |

## Verification
The wake flag can be set by a synchronized edge on a retained input and cleared by a software write in the same clock cycle. The bench provokes this by flipping a retained pad a fixed number of edges ahead so the synchronized change and the clearing write land on the same edge, then expects the flag to survive; a later clearing write with no edge pending must drop it. A second overlap is a core power-good drop while the retained bank holds non-default values, judged by reading both banks afterwards.

// File: rtl/twin_gpio_pkg.sv
package twin_gpio_pkg;

  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 8;
  localparam int CORE_N   = 10;
  localparam int SUS_N    = 4;
  localparam int CORE_BYTES = (CORE_N + DATA_W - 1) / DATA_W;

  localparam logic [ADDR_W-1:0] OFS_CORE_EN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CORE_DIR = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CORE_LVL = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_SUS_EN   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_SUS_DIR  = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_SUS_LVL  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_WAKE     = 6'h2C;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_CORE_EN0, RD_CORE_EN1,
    RD_CORE_DIR0, RD_CORE_DIR1,
    RD_CORE_LVL0, RD_CORE_LVL1,
    RD_SUS_EN, RD_SUS_DIR, RD_SUS_LVL,
    RD_WAKE
  } rdSelT;

  typedef struct packed {
    logic [CORE_BYTES-1:0] coreEnWr;
    logic [CORE_BYTES-1:0] coreDirWr;
    logic [CORE_BYTES-1:0] coreLvlWr;
    logic                  susEnWr;
    logic                  susDirWr;
    logic                  susLvlWr;
    logic                  wakeClrWr;
    logic                  rdEn;
    rdSelT                 rdSel;
  } strobeT;

endpackage

// File: rtl/twin_gpio_ctrl.sv
module twin_gpio_ctrl
  import twin_gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              wrDataBit0,
  output strobeT            stb
);

  rdSelT sel;

  always_comb begin
    sel = RD_NONE;
    unique case (busAddr)
      OFS_CORE_EN:        sel = RD_CORE_EN0;
      OFS_CORE_EN + 6'd1: sel = RD_CORE_EN1;
      OFS_CORE_DIR:       sel = RD_CORE_DIR0;
      OFS_CORE_DIR + 6'd1: sel = RD_CORE_DIR1;
      OFS_CORE_LVL:       sel = RD_CORE_LVL0;
      OFS_CORE_LVL + 6'd1: sel = RD_CORE_LVL1;
      OFS_SUS_EN:         sel = RD_SUS_EN;
      OFS_SUS_DIR:        sel = RD_SUS_DIR;
      OFS_SUS_LVL:        sel = RD_SUS_LVL;
      OFS_WAKE:           sel = RD_WAKE;
      default:            sel = RD_NONE;
    endcase
  end

  always_comb begin
    stb = '0;
    stb.rdEn  = busRd;
    stb.rdSel = busRd ? sel : RD_NONE;
    if (busWr) begin
      stb.coreEnWr[0]  = (sel == RD_CORE_EN0);
      stb.coreEnWr[1]  = (sel == RD_CORE_EN1);
      stb.coreDirWr[0] = (sel == RD_CORE_DIR0);
      stb.coreDirWr[1] = (sel == RD_CORE_DIR1);
      stb.coreLvlWr[0] = (sel == RD_CORE_LVL0);
      stb.coreLvlWr[1] = (sel == RD_CORE_LVL1);
      stb.susEnWr      = (sel == RD_SUS_EN);
      stb.susDirWr     = (sel == RD_SUS_DIR);
      stb.susLvlWr     = (sel == RD_SUS_LVL);
      stb.wakeClrWr    = (sel == RD_WAKE) && wrDataBit0;
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.coreEnWr, stb.coreDirWr, stb.coreLvlWr,
              stb.susEnWr, stb.susDirWr, stb.susLvlWr, stb.wakeClrWr})); // R2

endmodule

// File: rtl/twin_gpio_dp.sv
module twin_gpio_dp
  import twin_gpio_pkg::*;
#(
  parameter int               RSVD_PIN    = 7,
  parameter logic [CORE_N-1:0] CORE_EN_RST = 10'h07F,
  parameter logic [SUS_N-1:0]  SUS_EN_RST  = 4'h7
)(
  input  logic                 clk,
  input  logic                 coreRstN,
  input  logic                 susRstN,
  input  strobeT               stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 sleepIn,
  input  logic [CORE_N+SUS_N-1:0] padIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [CORE_N+SUS_N-1:0] padOut,
  output logic [CORE_N+SUS_N-1:0] padOe,
  output logic                 wakeReq
);

  localparam int CORE_W = CORE_BYTES * DATA_W;

  logic [CORE_N-1:0] coreEn, coreDir, coreLvl, coreSync1, coreSync2;
  logic [SUS_N-1:0]  susEn, susDir, susLvl, susSync1, susSync2, susPrev;
  logic              wakeFlag;
  logic              wakeEvent;
  logic [DATA_W-1:0] rdNext;

  // Core bank configuration, one flop per implemented pin
  for (genvar i = 0; i < CORE_N; i++) begin : g_core
    localparam int BYTE = i / DATA_W;
    localparam int BIT  = i % DATA_W;
    if (i == RSVD_PIN) begin : g_rsvd
      always_ff @(posedge clk or negedge coreRstN)
        if (!coreRstN) coreEn[i] <= 1'b0;
        else           coreEn[i] <= 1'b0;
    end else begin : g_norm
      always_ff @(posedge clk or negedge coreRstN)
        if (!coreRstN)               coreEn[i] <= CORE_EN_RST[i];
        else if (stb.coreEnWr[BYTE]) coreEn[i] <= wrData[BIT];
    end
    always_ff @(posedge clk or negedge coreRstN) begin
      if (!coreRstN) begin
        coreDir[i] <= 1'b1;
        coreLvl[i] <= 1'b0;
      end else begin
        if (stb.coreDirWr[BYTE]) coreDir[i] <= wrData[BIT];
        if (stb.coreLvlWr[BYTE]) coreLvl[i] <= wrData[BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) begin
      coreSync1 <= '0;
      coreSync2 <= '0;
    end else begin
      coreSync1 <= padIn[CORE_N-1:0];
      coreSync2 <= coreSync1;
    end
  end

  // Retained bank, suspend-domain reset only
  always_ff @(posedge clk or negedge susRstN) begin
    if (!susRstN) begin
      susEn    <= SUS_EN_RST;
      susDir   <= '1;
      susLvl   <= '0;
      susSync1 <= '0;
      susSync2 <= '0;
      susPrev  <= '0;
    end else begin
      if (stb.susEnWr)  susEn  <= wrData[SUS_N-1:0];
      if (stb.susDirWr) susDir <= wrData[SUS_N-1:0];
      if (stb.susLvlWr) susLvl <= wrData[SUS_N-1:0];
      susSync1 <= padIn[CORE_N+SUS_N-1:CORE_N];
      susSync2 <= susSync1;
      susPrev  <= susSync2;
    end
  end

  assign wakeEvent = sleepIn && (|((susSync2 ^ susPrev) & susEn & susDir));

  // Sticky flag: a new event outranks a clearing write in the same cycle
  always_ff @(posedge clk or negedge susRstN) begin
    if (!susRstN) wakeFlag <= 1'b0;
    else          wakeFlag <= (wakeFlag & ~stb.wakeClrWr) | wakeEvent;
  end

  // Read path
  logic [CORE_W-1:0] coreEnW, coreDirW, coreLvlW;
  assign coreEnW  = CORE_W'(coreEn);
  assign coreDirW = CORE_W'(coreDir);
  assign coreLvlW = CORE_W'(coreSync2);

  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      RD_CORE_EN0:  rdNext = coreEnW[7:0];
      RD_CORE_EN1:  rdNext = coreEnW[15:8];
      RD_CORE_DIR0: rdNext = coreDirW[7:0];
      RD_CORE_DIR1: rdNext = coreDirW[15:8];
      RD_CORE_LVL0: rdNext = coreLvlW[7:0];
      RD_CORE_LVL1: rdNext = coreLvlW[15:8];
      RD_SUS_EN:    rdNext = DATA_W'(susEn);
      RD_SUS_DIR:   rdNext = DATA_W'(susDir);
      RD_SUS_LVL:   rdNext = DATA_W'(susSync2);
      RD_WAKE:      rdNext = DATA_W'(wakeFlag);
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge susRstN) begin
    if (!susRstN)      rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
    else               rdData <= '0;
  end

  assign padOut  = {susLvl, coreLvl};
  assign padOe   = {susEn & ~susDir, coreEn & ~coreDir};
  assign wakeReq = wakeFlag;

  AST_RSVD_EN_LOW: assert property (@(posedge clk) disable iff (!coreRstN)
    stb.coreEnWr[RSVD_PIN/DATA_W] |=> !coreEn[RSVD_PIN]); // R6
  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!susRstN)
    $rose(wakeFlag) |-> $past(sleepIn)); // R9
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!susRstN)
    (wakeFlag && !stb.wakeClrWr) |=> wakeFlag); // R10
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!susRstN)
    !stb.rdEn |=> (rdData == '0)); // R11

endmodule

// File: rtl/twin_domain_gpio.sv
module twin_domain_gpio
  import twin_gpio_pkg::*;
(
  input  logic                    clk,
  input  logic                    corePwrGoodN,
  input  logic                    susRstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [DATA_W-1:0]       busWrData,
  input  logic                    busWr,
  input  logic                    busRd,
  output logic [DATA_W-1:0]       busRdData,
  input  logic                    sleepIn,
  input  logic [CORE_N+SUS_N-1:0] padIn,
  output logic [CORE_N+SUS_N-1:0] padOut,
  output logic [CORE_N+SUS_N-1:0] padOe,
  output logic                    wakeReq
);

  strobeT stb;

  twin_gpio_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (susRstN),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busRd      (busRd),
    .wrDataBit0 (busWrData[0]),
    .stb        (stb)
  );

  twin_gpio_dp u_dp (
    .clk      (clk),
    .coreRstN (corePwrGoodN),
    .susRstN  (susRstN),
    .stb      (stb),
    .wrData   (busWrData),
    .sleepIn  (sleepIn),
    .padIn    (padIn),
    .rdData   (busRdData),
    .padOut   (padOut),
    .padOe    (padOe),
    .wakeReq  (wakeReq)
  );

endmodule

// File: tb/twin_domain_gpio_bench.sv
`timescale 1ns/1ps
module twin_domain_gpio_bench;

  logic        clk = 1'b0;
  logic        corePwrGoodN = 1'b0;
  logic        susRstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic        sleepIn = 1'b0;
  logic [13:0] extDrive = '0;
  logic [13:0] padIn, padOut, padOe;
  logic        wakeReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  // Pads: a driven pad shows the driven value, else the external level
  assign padIn = (padOe & padOut) | (~padOe & extDrive);

  twin_domain_gpio u_twin_domain_gpio (
    .clk(clk), .corePwrGoodN(corePwrGoodN), .susRstN(susRstN),
    .busAddr(busAddr), .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData), .sleepIn(sleepIn), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .wakeReq(wakeReq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic readCheck(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] d;
    busRead(a, d);
    check(tag, 16'(d), 16'(exp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fullReset();
    @(negedge clk);
    corePwrGoodN = 1'b0; susRstN = 1'b0;
    idle(2);
    corePwrGoodN = 1'b1; susRstN = 1'b1;
    idle(1);
  endtask

  // {address, write data, expected read-back}
  localparam int NVEC = 8;
  localparam logic [21:0] VEC [NVEC] = '{
    {6'h00, 8'hFF, 8'h7F},
    {6'h01, 8'hFF, 8'h03},
    {6'h04, 8'hA5, 8'hA5},
    {6'h05, 8'hFE, 8'h02},
    {6'h20, 8'hF8, 8'h08},
    {6'h24, 8'h35, 8'h05},
    {6'h10, 8'hFF, 8'h00},
    {6'h3F, 8'hFF, 8'h00}
  };

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3);
    corePwrGoodN = 1'b1; susRstN = 1'b1;
    idle(1);

    // R1 reset state
    readCheck("R1 core en0", 6'h00, 8'h7F);
    readCheck("R1 core en1", 6'h01, 8'h00);
    readCheck("R1 core dir0", 6'h04, 8'hFF);
    readCheck("R1 core dir1", 6'h05, 8'h03);
    readCheck("R1 sus en", 6'h20, 8'h07);
    readCheck("R1 sus dir", 6'h24, 8'h0F);
    readCheck("R1 wake", 6'h2C, 8'h00);
    check("R1 no pin driven", 16'(padOe), 16'h0);

    // R11 read data clears on the cycle without a read
    busRead(6'h00, d);
    @(negedge clk);
    check("R11 idle read data", 16'(busRdData), 16'h0);

    // R2/R5/R6 write and read-back table
    for (int v = 0; v < NVEC; v++) begin
      busWrite(VEC[v][21:16], VEC[v][15:8]);
      readCheck($sformatf("R2/R5/R6 vec%0d", v), VEC[v][21:16], VEC[v][7:0]);
    end

    fullReset();
    // R3 and R6: drive core 0..6 and 8..9
    busWrite(6'h01, 8'h03);
    busWrite(6'h04, 8'h00);
    busWrite(6'h05, 8'h00);
    busWrite(6'h08, 8'hD5);
    busWrite(6'h09, 8'h02);
    check("R3 core oe", 16'(padOe[9:0]), 16'h37F);
    check("R3 core out", 16'(padOut[9:8]), 16'h2);
    check("R3 core out low", 16'(padOut[6:0]), 16'h55);
    check("R6 reserved pin undriven", 16'(padOe[7]), 16'h0);
    // R4 level read through synchronizer, pin 7 from outside
    extDrive = '0;
    idle(3);
    readCheck("R4 core lvl0", 6'h08, 8'h55);
    readCheck("R4 core lvl1", 6'h09, 8'h02);
    extDrive[7] = 1'b1;
    idle(3);
    readCheck("R4 core lvl0 ext", 6'h08, 8'hD5);
    // R5 level upper bits
    readCheck("R5 core lvl1 upper", 6'h09, 8'h02);
    // R3 disabled retained pin 3 stays floating
    busWrite(6'h24, 8'h00);
    busWrite(6'h28, 8'h0F);
    check("R3 sus oe", 16'(padOe[13:10]), 16'h7);
    idle(3);
    readCheck("R4 sus lvl", 6'h28, 8'h07);

    // R7 core power-good drop keeps retained bank
    busWrite(6'h20, 8'h0F);
    @(negedge clk); corePwrGoodN = 1'b0;
    idle(2); corePwrGoodN = 1'b1; idle(1);
    readCheck("R7 core en0", 6'h00, 8'h7F);
    readCheck("R7 core dir1", 6'h05, 8'h03);
    readCheck("R7 sus en kept", 6'h20, 8'h0F);
    readCheck("R7 sus dir kept", 6'h24, 8'h00);

    // R9 wake detection
    fullReset();
    extDrive = '0;
    busWrite(6'h20, 8'h0D);   // pin 11 disabled
    busWrite(6'h24, 8'h0B);   // pin 12 output
    idle(3);
    extDrive[10] = 1'b1;      // awake: no wake
    idle(5);
    check("R9 no wake while awake", 16'(wakeReq), 16'h0);
    sleepIn = 1'b1;
    idle(2);
    extDrive[11] = 1'b1;      // disabled pin
    idle(5);
    check("R9 disabled pin ignored", 16'(wakeReq), 16'h0);
    busWrite(6'h28, 8'h04);   // output pin toggles
    idle(5);
    check("R9 output pin ignored", 16'(wakeReq), 16'h0);
    extDrive[10] = 1'b0;
    idle(5);
    check("R9 wake set", 16'(wakeReq), 16'h1);
    readCheck("R9 wake readback", 6'h2C, 8'h01);

    // R10 write-one-to-clear
    busWrite(6'h2C, 8'h00);
    check("R10 write zero keeps", 16'(wakeReq), 16'h1);
    busWrite(6'h2C, 8'h01);
    check("R10 write one clears", 16'(wakeReq), 16'h0);
    // R10 event and clear on the same edge
    @(negedge clk); extDrive[10] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 6'h2C; busWrData = 8'h01; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    check("R10 set beats clear", 16'(wakeReq), 16'h1);
    idle(3);
    busWrite(6'h2C, 8'h01);
    check("R10 clear after overlap", 16'(wakeReq), 16'h0);

    // R8 suspend reset clears retained bank and flag
    @(negedge clk); extDrive[10] = 1'b0;
    idle(5);
    check("R8 wake set before reset", 16'(wakeReq), 16'h1);
    @(negedge clk); susRstN = 1'b0;
    idle(2); susRstN = 1'b1; idle(1);
    sleepIn = 1'b0;
    check("R8 wake cleared", 16'(wakeReq), 16'h0);
    readCheck("R8 sus en", 6'h20, 8'h07);
    readCheck("R8 sus dir", 6'h24, 8'h0F);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule